// File: doc/BRIEF.md
# Sixteen-Channel Trigger Front-End Reducer

This block condenses sixteen photomultiplier sample streams into one summary word per clock cycle for the next trigger layer. Every cycle it takes one baseline-corrected 10-bit sample per channel. It scales each sample by its own gain coefficient. From the scaled values it forms three results: the total charge, the index of the channel with the largest charge, and the earliest leading-edge arrival time within a sliding window of recent cycles.

A new summary comes out on every cycle, and the delay from input to output is always the same. A mode input turns off the peak index and the arrival time, so the result carries only the charge sum. Boards that serve only the energy measurement use this mode. The sample, gain, threshold and mode inputs travel down the pipeline together, so each summary word is built from one consistent set of inputs.

Top module: `trig_fe_reducer`

## Requirements
- R1: Each channel's equalised value is floor(sample × coef / 256). The sample is unsigned 10-bit. The coefficient is unsigned 10-bit with 8 fractional bits, so 256 means unity gain. Channel i uses bits [10i+9:10i] of both the sample bus and the gain bus.
- R2: `sum_out` is the exact sum of all sixteen equalised values. It is 16 bits wide and can never overflow: the largest possible sum is 65408.
- R3: `peak_idx` gives the channel with the largest equalised value. When several channels tie for the largest value, the lowest channel index wins.
- R4: A channel crosses at a sample when its equalised value is at or above `thr_in` and its equalised value for the previous sample was below `thr_in`. The previous value is taken as 0 for the first sample after reset.
- R5: A channel stays in the window for 16 samples after its most recent crossing. Its arrival time is 15 minus the number of samples since that crossing. `t_early` is the smallest arrival time among all channels in the window, and `t_valid` is 1 whenever at least one channel is in the window.
- R6: When no channel is in the window, `t_early` is 4'hF and `t_valid` is 0.
- R7: While `energy_only` is 1, that summary word has `peak_idx` = 0, `t_early` = 4'hF and `t_valid` = 0. `sum_out` is unchanged by the mode, and the window history keeps being tracked.
- R8: The sample, gain, threshold and mode captured at one rising edge appear on the outputs after the fifth following edge. That is six register stages in total, and one result is produced per cycle.
- R9: While `rst` is high, the outputs read `sum_out` = 0, `peak_idx` = 0, `t_early` = 4'hF and `t_valid` = 0. Reset also empties the arrival window and clears the previous-sample values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_in | input | 160 | Sixteen 10-bit samples, channel i at [10i+9:10i] |
| gain_in | input | 160 | Sixteen 10-bit gain coefficients with 8 fractional bits |
| thr_in | input | 12 | Crossing threshold, compared with equalised values |
| energy_only | input | 1 | 1 suppresses the peak index and time outputs |
| sum_out | output | 16 | Total equalised charge |
| peak_idx | output | 4 | Channel holding the largest charge |
| t_early | output | 4 | Earliest arrival time in the window |
| t_valid | output | 1 | At least one crossing lies in the window |

## Verification
Every result is due six register stages after its inputs are captured. That holds for the sum, the peak index, the arrival time and the mode gating alike. The arrival window itself depends on the sixteen samples before that.

The bench drives a new input set on every falling edge. It models the expected summary for that set straight from the requirements and queues it behind five entries that stand for the reset contents of the pipeline. After each rising edge it compares the outputs with the oldest queued entry, so every comparison lands exactly on the cycle in which that result is due. The stimulus includes ties, full-scale gains, staggered pulses that age out of the window, and stretches in energy-only mode.

// File: rtl/trig_fe_pkg.sv
package trig_fe_pkg;
  localparam int P_NCH   = 16;  // channels per board
  localparam int P_SW    = 10;  // sample width
  localparam int P_GW    = 10;  // gain coefficient width
  localparam int P_GFRAC = 8;   // fractional bits of the gain
  localparam int P_TW    = 4;   // arrival time width, window = 2**P_TW samples
  localparam int P_GRP   = 4;   // channels per first-level reduction group
endpackage

// File: rtl/trig_fe_argmax.sv
// Combinational argmax over N values; on equal values the lower index wins.
module trig_fe_argmax #(
  parameter int N  = 4,
  parameter int VW = 12,
  localparam int IW = $clog2(N)
) (
  input  logic [N*VW-1:0] vals_flat,
  output logic [VW-1:0]   best,
  output logic [IW-1:0]   idx
);
  localparam int NODES = 2*N - 1;

  logic [VW-1:0] tv [NODES];
  logic [IW-1:0] ti [NODES];

  // Heap layout: leaves at N-1..2N-2 in channel order, so each left subtree
  // holds the lower indices and only a strictly larger right value wins.
  always_comb begin
    for (int g = 0; g < N; g++) begin
      tv[N-1+g] = vals_flat[g*VW +: VW];
      ti[N-1+g] = IW'(g);
    end
    for (int k = N-2; k >= 0; k--) begin
      if (tv[2*k+2] > tv[2*k+1]) begin
        tv[k] = tv[2*k+2];
        ti[k] = ti[2*k+2];
      end else begin
        tv[k] = tv[2*k+1];
        ti[k] = ti[2*k+1];
      end
    end
  end

  assign best = tv[0];
  assign idx  = ti[0];
endmodule

// File: rtl/trig_fe_gain_eq.sv
// Registered per-channel gain equalisation (pipeline stage 2).
module trig_fe_gain_eq #(
  parameter int NCH   = 16,
  parameter int SW    = 10,
  parameter int GW    = 10,
  parameter int GFRAC = 8,
  localparam int EW   = SW + GW - GFRAC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH*SW-1:0] smp_flat,
  input  logic [NCH*GW-1:0] gain_flat,
  output logic [NCH*EW-1:0] eq_flat
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SW+GW-1:0] prod;
    assign prod = smp_flat[c*SW +: SW] * gain_flat[c*GW +: GW];
    always_ff @(posedge clk) begin
      if (rst) eq_flat[c*EW +: EW] <= '0;
      else     eq_flat[c*EW +: EW] <= prod[SW+GW-1:GFRAC];
    end
  end
endmodule

// File: rtl/trig_fe_arrival.sv
// Leading-edge detection, per-channel age tracking and earliest-time search.
// Stage 3: ages. Stage 4: group winners. Stage 5: final winner.
module trig_fe_arrival #(
  parameter int NCH = 16,
  parameter int EW  = 12,
  parameter int TW  = 4,
  parameter int GRP = 4,
  localparam int NGRP = NCH / GRP,
  localparam int AW   = TW + 1,
  localparam int WIN  = 2**TW,
  localparam int KW   = TW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH*EW-1:0] eq_flat,
  input  logic [EW-1:0]     thr,
  output logic [TW-1:0]     t_early,
  output logic              t_valid
);
  logic [EW-1:0] eq_prev [NCH];
  logic [AW-1:0] age     [NCH];
  logic [KW-1:0] key     [NCH];
  logic [KW-1:0] gkey_c  [NGRP];
  logic [KW-1:0] gkey_q  [NGRP];
  logic [KW-1:0] fkey_c, fkey_q;

  // Age counts samples since the most recent crossing and rests at WIN
  // when the channel is outside the window.
  always_ff @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (rst) begin
        eq_prev[c] <= '0;
        age[c]     <= AW'(WIN);
      end else begin
        eq_prev[c] <= eq_flat[c*EW +: EW];
        if (eq_flat[c*EW +: EW] >= thr && eq_prev[c] < thr) age[c] <= '0;
        else if (age[c] != AW'(WIN))                        age[c] <= age[c] + 1'b1;
      end
    end
  end

  // Earliest arrival is the oldest crossing; key = {in_window, age}.
  always_comb begin
    for (int c = 0; c < NCH; c++)
      key[c] = (age[c] < AW'(WIN)) ? {1'b1, age[c][TW-1:0]} : '0;
    for (int g = 0; g < NGRP; g++) begin
      gkey_c[g] = '0;
      for (int j = 0; j < GRP; j++)
        if (key[g*GRP+j] > gkey_c[g]) gkey_c[g] = key[g*GRP+j];
    end
    fkey_c = '0;
    for (int g = 0; g < NGRP; g++)
      if (gkey_q[g] > fkey_c) fkey_c = gkey_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < NGRP; g++) gkey_q[g] <= '0;
      fkey_q <= '0;
    end else begin
      for (int g = 0; g < NGRP; g++) gkey_q[g] <= gkey_c[g];
      fkey_q <= fkey_c;
    end
  end

  // time = (WIN-1) - age; an empty key yields all ones with valid low
  assign t_valid = fkey_q[TW];
  assign t_early = ~fkey_q[TW-1:0];

  logic any_grp;
  always_comb begin
    any_grp = 1'b0;
    for (int g = 0; g < NGRP; g++) any_grp = any_grp | gkey_q[g][TW];
  end

  // R5: a group holding an in-window channel makes the final result valid
  assert_valid_propagate_R5: assert property (@(posedge clk) disable iff (rst)
    any_grp |=> t_valid);
endmodule

// File: rtl/trig_fe_reducer.sv
// Sixteen-channel trigger reducer: charge sum, peak channel, earliest time.
module trig_fe_reducer
  import trig_fe_pkg::*;
#(
  parameter int NCH   = P_NCH,
  parameter int SW    = P_SW,
  parameter int GW    = P_GW,
  parameter int GFRAC = P_GFRAC,
  parameter int TW    = P_TW,
  parameter int GRP   = P_GRP,
  localparam int EW   = SW + GW - GFRAC,
  localparam int IW   = $clog2(NCH),
  localparam int SUMW = EW + IW,
  localparam int NGRP = NCH / GRP,
  localparam int GIW  = $clog2(GRP),
  localparam int NGIW = $clog2(NGRP),
  localparam int PSW  = EW + GIW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH*SW-1:0] smp_in,
  input  logic [NCH*GW-1:0] gain_in,
  input  logic [EW-1:0]     thr_in,
  input  logic              energy_only,
  output logic [SUMW-1:0]   sum_out,
  output logic [IW-1:0]     peak_idx,
  output logic [TW-1:0]     t_early,
  output logic              t_valid
);
  // ---- stage 1: capture every input together ----
  logic [NCH*SW-1:0] s1_smp;
  logic [NCH*GW-1:0] s1_gain;
  logic [EW-1:0]     s1_thr, s2_thr;
  logic              s1_mode, s2_mode, s3_mode, s4_mode, s5_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_smp <= '0; s1_gain <= '0; s1_thr <= '0; s2_thr <= '0;
      s1_mode <= 1'b0; s2_mode <= 1'b0; s3_mode <= 1'b0;
      s4_mode <= 1'b0; s5_mode <= 1'b0;
    end else begin
      s1_smp <= smp_in; s1_gain <= gain_in; s1_thr <= thr_in; s2_thr <= s1_thr;
      s1_mode <= energy_only; s2_mode <= s1_mode; s3_mode <= s2_mode;
      s4_mode <= s3_mode; s5_mode <= s4_mode;
    end
  end

  // ---- stage 2: gain equalisation ----
  logic [NCH*EW-1:0] s2_eq;
  trig_fe_gain_eq #(.NCH(NCH), .SW(SW), .GW(GW), .GFRAC(GFRAC)) u_gain (
    .clk(clk), .rst(rst), .smp_flat(s1_smp), .gain_flat(s1_gain), .eq_flat(s2_eq)
  );

  // ---- stage 3: per-group partial sums and group winners ----
  logic [PSW-1:0]    s3_psum [NGRP];
  logic [GIW-1:0]    s3_gidx [NGRP];
  logic [NGRP*EW-1:0] s3_gval_flat;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [EW-1:0]  gbest;
    logic [GIW-1:0] gidx;
    logic [PSW-1:0] psum;
    trig_fe_argmax #(.N(GRP), .VW(EW)) u_gmax (
      .vals_flat(s2_eq[g*GRP*EW +: GRP*EW]), .best(gbest), .idx(gidx)
    );
    always_comb begin
      psum = '0;
      for (int j = 0; j < GRP; j++) psum = psum + PSW'(s2_eq[(g*GRP+j)*EW +: EW]);
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        s3_psum[g] <= '0; s3_gidx[g] <= '0; s3_gval_flat[g*EW +: EW] <= '0;
      end else begin
        s3_psum[g] <= psum; s3_gidx[g] <= gidx; s3_gval_flat[g*EW +: EW] <= gbest;
      end
    end
  end

  // ---- stage 4: total and overall winner ----
  logic [EW-1:0]   fbest;
  logic [NGIW-1:0] fgrp;
  logic [SUMW-1:0] tot;
  logic [SUMW-1:0] s4_sum, s5_sum;
  logic [EW-1:0]   s4_best;
  logic [IW-1:0]   s4_idx, s5_idx;

  // lower group wins ties, lower lane wins inside a group: lowest index overall
  trig_fe_argmax #(.N(NGRP), .VW(EW)) u_fmax (
    .vals_flat(s3_gval_flat), .best(fbest), .idx(fgrp)
  );

  always_comb begin
    tot = '0;
    for (int g = 0; g < NGRP; g++) tot = tot + SUMW'(s3_psum[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s4_sum <= '0; s4_best <= '0; s4_idx <= '0; s5_sum <= '0; s5_idx <= '0;
    end else begin
      s4_sum  <= tot;
      s4_best <= fbest;
      s4_idx  <= {fgrp, s3_gidx[fgrp]};
      s5_sum  <= s4_sum;
      s5_idx  <= s4_idx;
    end
  end

  // ---- stages 3..5: arrival time ----
  logic [TW-1:0] arr_time;
  logic          arr_valid;
  trig_fe_arrival #(.NCH(NCH), .EW(EW), .TW(TW), .GRP(GRP)) u_arr (
    .clk(clk), .rst(rst), .eq_flat(s2_eq), .thr(s2_thr),
    .t_early(arr_time), .t_valid(arr_valid)
  );

  // ---- stage 6: output register with mode gating ----
  always_ff @(posedge clk) begin
    if (rst) begin
      sum_out <= '0; peak_idx <= '0; t_early <= '1; t_valid <= 1'b0;
    end else begin
      sum_out  <= s5_sum;
      peak_idx <= s5_mode ? '0 : s5_idx;
      t_early  <= s5_mode ? '1 : arr_time;
      t_valid  <= !s5_mode && arr_valid;
    end
  end

  // R2: the total can neither fall below the peak nor exceed NCH times it
  assert_sum_bounds_R2: assert property (@(posedge clk) disable iff (rst)
    (s4_sum >= SUMW'(s4_best)) && (s4_sum <= SUMW'(s4_best) * SUMW'(NCH)));

  // R6: an empty window always reports the all-ones code
  assert_none_code_R6: assert property (@(posedge clk) disable iff (rst)
    !t_valid |-> (t_early == '1));

  // R7: energy-only words carry no peak index and no time
  assert_energy_only_R7: assert property (@(posedge clk) disable iff (rst)
    s5_mode |=> (peak_idx == '0 && !t_valid && t_early == '1));
endmodule

// File: tb/trig_fe_reducer_bench.sv
module trig_fe_reducer_bench;
  localparam int NCH = 16;

  typedef struct {
    int sum; int idx; int tm; int vld; int mode;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [159:0] smp_in = '0;
  logic [159:0] gain_in = '0;
  logic [11:0]  thr_in = '0;
  logic         energy_only = 1'b0;
  logic [15:0]  sum_out;
  logic [3:0]   peak_idx;
  logic [3:0]   t_early;
  logic         t_valid;

  trig_fe_reducer u_trig_fe_reducer (
    .clk(clk), .rst(rst), .smp_in(smp_in), .gain_in(gain_in), .thr_in(thr_in),
    .energy_only(energy_only), .sum_out(sum_out), .peak_idx(peak_idx),
    .t_early(t_early), .t_valid(t_valid)
  );

  always #4 clk = ~clk;

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  int   smp [NCH];
  int   gn  [NCH];
  int   thr = 4095;
  bit   mode = 0;
  int   n = 0;
  int   lastx  [NCH];
  int   prev_eq[NCH];
  exp_t q[$];

  function automatic exp_t zero_result();
    exp_t e;
    e.sum = 0; e.idx = 0; e.tm = 15; e.vld = 0; e.mode = 0;
    return e;
  endfunction

  // behavioural model of one input set (R1..R7)
  task automatic apply_and_model();
    exp_t e;
    int eq[NCH];
    int best_age, best_val;
    for (int i = 0; i < NCH; i++) begin
      smp_in[i*10 +: 10]  = smp[i][9:0];
      gain_in[i*10 +: 10] = gn[i][9:0];
    end
    thr_in = thr[11:0];
    energy_only = mode;
    e.sum = 0; e.idx = 0; best_val = -1; best_age = -1;
    for (int i = 0; i < NCH; i++) begin
      eq[i] = (smp[i] * gn[i]) / 256;                    // R1
      e.sum += eq[i];                                    // R2
      if (eq[i] > best_val) begin best_val = eq[i]; e.idx = i; end   // R3
      if (eq[i] >= thr && prev_eq[i] < thr) lastx[i] = n;            // R4
      if (n - lastx[i] < 16 && n - lastx[i] > best_age) best_age = n - lastx[i];
      prev_eq[i] = eq[i];
    end
    e.vld = (best_age >= 0);
    e.tm  = e.vld ? 15 - best_age : 15;                  // R5, R6
    e.mode = mode;
    if (mode) begin e.idx = 0; e.tm = 15; e.vld = 0; end // R7
    n++;
    q.push_back(e);
  endtask

  // R8: result of the set applied five edges earlier is due now
  task automatic step();
    exp_t e;
    apply_and_model();
    @(negedge clk);
    e = q.pop_front();
    checks++;
    if (sum_out !== 16'(e.sum)) begin
      errors++;
      $display("FAIL R2 sum_out got %0d exp %0d (cycle %0d)", sum_out, e.sum, n);
    end
    checks++;
    if (peak_idx !== 4'(e.idx)) begin
      errors++;
      if (e.mode) $display("FAIL R7 peak_idx got %0d exp %0d", peak_idx, e.idx);
      else        $display("FAIL R3 peak_idx got %0d exp %0d", peak_idx, e.idx);
    end
    checks++;
    if (t_early !== 4'(e.tm) || t_valid !== 1'(e.vld)) begin
      errors++;
      if (e.mode)     $display("FAIL R7 time got %0d/%0d exp %0d/%0d", t_early, t_valid, e.tm, e.vld);
      else if (!e.vld) $display("FAIL R6 time got %0d/%0d exp %0d/%0d", t_early, t_valid, e.tm, e.vld);
      else            $display("FAIL R5 time got %0d/%0d exp %0d/%0d", t_early, t_valid, e.tm, e.vld);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin
      smp[i] = 0; gn[i] = 256; lastx[i] = -1000; prev_eq[i] = 0;
    end
    repeat (4) @(negedge clk);
    // R9: reset values
    checks++;
    if (sum_out !== 16'd0 || peak_idx !== 4'd0 || t_early !== 4'hF || t_valid !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset outputs got %0d %0d %0d %0d exp 0 0 15 0",
               sum_out, peak_idx, t_early, t_valid);
    end
    rst = 1'b0;
    for (int k = 0; k < 5; k++) q.push_back(zero_result());

    // unity gain, random data, threshold out of reach (R1, R2, R3, R6)
    for (int c = 0; c < 20; c++) begin
      for (int i = 0; i < NCH; i++) smp[i] = $urandom_range(0, 1023);
      step();
    end
    // all equal: lowest channel wins (R3)
    for (int i = 0; i < NCH; i++) smp[i] = 100;
    step(); step();
    // tie between channels 5 and 9 (R3)
    for (int i = 0; i < NCH; i++) smp[i] = 20;
    smp[5] = 900; smp[9] = 900;
    step(); step();
    // full scale on every channel: largest sum (R2)
    for (int i = 0; i < NCH; i++) begin smp[i] = 1023; gn[i] = 1023; end
    step(); step();
    // random gains (R1)
    for (int c = 0; c < 60; c++) begin
      for (int i = 0; i < NCH; i++) begin
        smp[i] = $urandom_range(0, 1023); gn[i] = $urandom_range(0, 1023);
      end
      step();
    end
    // staggered leading edges, then expiry of the window (R4, R5, R6)
    thr = 500;
    for (int i = 0; i < NCH; i++) begin smp[i] = 100; gn[i] = 256; end
    for (int c = 0; c < 45; c++) begin
      smp[3] = (c >= 4)  ? 800 : 100;
      smp[7] = (c >= 6)  ? 800 : 100;
      smp[12] = (c >= 30 && c < 33) ? 600 : 100;
      step();
    end
    // pulse trains with energy-only stretches (R4, R5, R7)
    for (int c = 0; c < 300; c++) begin
      mode = (c % 50) >= 35;
      for (int i = 0; i < NCH; i++) begin
        smp[i] = ($urandom_range(0, 9) == 0) ? $urandom_range(400, 1023) : $urandom_range(0, 300);
        gn[i] = $urandom_range(200, 320);
      end
      if (c % 40 == 0) thr = $urandom_range(300, 900);
      step();
    end
    mode = 0;
    for (int c = 0; c < 10; c++) step();
    finish_run();
  end
endmodule